// File: doc/BRIEF.md
# Distributed-Arithmetic FIR Filter

This block computes a short FIR filter without any multiplier. It keeps the most recent samples in a tap line. It then walks through their bit positions one clock at a time, starting from the least significant bit. At each step, the bits taken from the same position of every held sample form an index into a small table. Each table entry holds the sum of the coefficients whose index bit is set. A shift-accumulator combines the table outputs into the filter result at full precision.

The table is computed at elaboration time from a coefficient parameter, so nothing is loaded at run time. Samples arrive over a valid/ready handshake. A new sample is accepted in the final bit cycle of the previous computation, so a steady stream runs at one sample, and one result, every `SAMPLE_W` clocks. The block does not change the sample rate.

Top module: `da_fir_filter`

## Requirements
- R1: The result is y = sum over k of c[k]*x[k]. Here x[0] is the newest accepted sample and x[NUM_TAPS-1] the oldest. Samples and coefficients are two's complement. The result is exact, with no rounding or saturation, and `y_o` is `SAMPLE_W + COEF_W + clog2(NUM_TAPS)` bits wide.
- R2: Each accepted sample enters tap 0, every other tap moves up by one, and the oldest sample is dropped. With the default coefficients {3, -7, 12, -128} for taps 0..3, an impulse of 1 followed by three zeros gives the outputs 3, -7, 12, -128.
- R3: `in_ready_o` is high when the block is idle or in the last bit cycle of a computation, and low in every other cycle. A sample is accepted on a rising edge where both `in_valid_i` and `in_ready_o` are high.
- R4: `out_valid_o` goes high for exactly one cycle, after the `SAMPLE_W`-th rising edge that follows the accepting edge.
- R5: `y_o` holds its value until the next `out_valid_o` pulse.
- R6: A sample offered while `in_ready_o` is low is ignored. It reaches neither the tap line nor any later result.
- R7: With `in_valid_i` held high, samples are accepted on every `SAMPLE_W`-th edge, and each result appears on the same edge that accepts the following sample.
- R8: The sign bit has negative weight. A sample of -128 (with an 8-bit width) or a series of -128 values gives the exact negative or positive products.
- R9: An asynchronous low on `rst_ni` clears the tap line and the result, drives `out_valid_o` low and `in_ready_o` high, and abandons any computation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Sample offered |
| in_ready_o | output | 1 | Sample can be taken this cycle |
| sample_i | input | SAMPLE_W | Two's-complement input sample |
| out_valid_o | output | 1 | One-cycle pulse: new result on `y_o` |
| y_o | output | SAMPLE_W+COEF_W+clog2(NUM_TAPS) | Filter result, two's complement |

## Verification
A result is due on the `SAMPLE_W`-th rising edge after its accepting edge. When samples run back to back, that edge is also the edge that accepts the next sample. The bench counts edges from each acceptance. It checks that `out_valid_o` is still low one edge before the result is due, then checks the pulse and the value at the following falling edge, and checks one cycle later that the pulse has ended and the value is held. `in_ready_o` is checked early in the computation, where it must be low, and in the final bit cycle, where it must be high. All outputs are sampled at falling edges.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;
  localparam int MAX_TAPS   = 8;
  localparam int MAX_COEF_W = 16;

  typedef logic signed [MAX_COEF_W-1:0] coef_t;
  typedef coef_t [MAX_TAPS-1:0]         coef_arr_t;

  // sum of the coefficients whose address bit is set
  function automatic int lut_entry(coef_arr_t c, int taps, int addr);
    int s;
    s = 0;
    for (int k = 0; k < taps; k++) begin
      if (((addr >> k) & 1) == 1) s += int'(c[k]);
    end
    return s;
  endfunction
endpackage

// File: rtl/da_fir_tap_line.sv
module da_fir_tap_line #(
  parameter int K     = 4,
  parameter int B     = 8,
  parameter int BIT_W = $clog2(B)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic [B-1:0]     sample_i,
  input  logic [BIT_W-1:0] bit_sel_i,
  output logic [K-1:0]     addr_o
);
  logic [B-1:0] taps_q [K];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < K; k++) taps_q[k] <= '0;
    end else if (shift_i) begin
      taps_q[0] <= sample_i;
      for (int k = 1; k < K; k++) taps_q[k] <= taps_q[k-1];
    end
  end

  for (genvar k = 0; k < K; k++) begin : g_addr
    assign addr_o[k] = taps_q[k][bit_sel_i];
  end
endmodule

// File: rtl/da_fir_ctrl.sv
module da_fir_ctrl #(
  parameter int B     = 8,
  parameter int BIT_W = $clog2(B)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  output logic             accept_o,
  output logic             busy_o,
  output logic             last_o,
  output logic [BIT_W-1:0] bit_sel_o
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(B - 1);

  logic             busy_q;
  logic [BIT_W-1:0] cnt_q;

  assign last_o     = busy_q && (cnt_q == LAST_BIT);
  assign in_ready_o = !busy_q || last_o;
  assign accept_o   = in_valid_i && in_ready_o;
  assign busy_o     = busy_q;
  assign bit_sel_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (last_o) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/da_fir_lut.sv
module da_fir_lut
  import da_fir_pkg::*;
#(
  parameter int        K      = 4,
  parameter int        SUM_W  = 10,
  parameter coef_arr_t COEFS  = '0
) (
  input  logic [K-1:0]            addr_i,
  output logic signed [SUM_W-1:0] partial_o
);
  localparam int DEPTH = 1 << K;

  logic signed [SUM_W-1:0] rom [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_rom
    assign rom[a] = SUM_W'(lut_entry(COEFS, K, a));
  end

  assign partial_o = rom[addr_i];
endmodule

// File: rtl/da_fir_accum.sv
module da_fir_accum #(
  parameter int B     = 8,
  parameter int SUM_W = 10,
  parameter int OUT_W = 18
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    en_i,
  input  logic                    neg_i,
  input  logic signed [SUM_W-1:0] partial_i,
  output logic signed [OUT_W-1:0] y_o,
  output logic                    valid_o
);
  logic signed [OUT_W-1:0] acc_q, acc_next, shifted, term;

  // LSB first: halve the running sum and add the new partial at weight 2^(B-1)
  always_comb begin
    shifted  = acc_q >>> 1;
    term     = {{(OUT_W-SUM_W){partial_i[SUM_W-1]}}, partial_i} <<< (B - 1);
    acc_next = neg_i ? (shifted - term) : (shifted + term);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      y_o     <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= en_i && neg_i;
      if (en_i && neg_i) y_o <= acc_next;
      if (clr_i)     acc_q <= '0;
      else if (en_i) acc_q <= acc_next;
    end
  end
endmodule

// File: rtl/da_fir_filter.sv
module da_fir_filter
  import da_fir_pkg::*;
#(
  parameter int        NUM_TAPS = 4,
  parameter int        SAMPLE_W = 8,
  parameter int        COEF_W   = 8,
  parameter coef_arr_t COEFS    = '{0, 0, 0, 0, -128, 12, -7, 3},
  localparam int       OUT_W    = SAMPLE_W + COEF_W + $clog2(NUM_TAPS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                out_valid_o,
  output logic [OUT_W-1:0]    y_o
);
  localparam int SUM_W = COEF_W + $clog2(NUM_TAPS);
  localparam int BIT_W = $clog2(SAMPLE_W);

  logic                    accept, busy, last;
  logic [BIT_W-1:0]        bit_sel;
  logic [NUM_TAPS-1:0]     addr;
  logic signed [SUM_W-1:0] partial;
  logic signed [OUT_W-1:0] y_s;

  da_fir_ctrl #(.B(SAMPLE_W), .BIT_W(BIT_W)) u_ctrl (
    .clk_i, .rst_ni, .in_valid_i, .in_ready_o,
    .accept_o(accept), .busy_o(busy), .last_o(last), .bit_sel_o(bit_sel)
  );

  da_fir_tap_line #(.K(NUM_TAPS), .B(SAMPLE_W), .BIT_W(BIT_W)) u_taps (
    .clk_i, .rst_ni, .shift_i(accept), .sample_i,
    .bit_sel_i(bit_sel), .addr_o(addr)
  );

  da_fir_lut #(.K(NUM_TAPS), .SUM_W(SUM_W), .COEFS(COEFS)) u_lut (
    .addr_i(addr), .partial_o(partial)
  );

  da_fir_accum #(.B(SAMPLE_W), .SUM_W(SUM_W), .OUT_W(OUT_W)) u_acc (
    .clk_i, .rst_ni, .clr_i(accept), .en_i(busy), .neg_i(last),
    .partial_i(partial), .y_o(y_s), .valid_o(out_valid_o)
  );

  assign y_o = y_s;
endmodule

// File: rtl/da_fir_checker.sv
module da_fir_checker #(
  parameter int B     = 8,
  parameter int OUT_W = 18
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             out_valid_o,
  input logic [OUT_W-1:0] y_o
);
  localparam int CNT_W = $clog2(B + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(B);

  // edges since acceptance, 0 when idle
  logic [CNT_W-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (in_valid_i && in_ready_o)  cnt_q <= CNT_W'(1);
    else if (cnt_q == FULL)             cnt_q <= '0;
    else if (cnt_q != '0)               cnt_q <= cnt_q + 1'b1;
  end

  a_r3_ready_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o == ((cnt_q == '0) || (cnt_q == FULL)));

  a_r4_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == FULL) |=> out_valid_o);

  a_r4_only_when_due: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != FULL) |=> !out_valid_o);

  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);

  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> $stable(y_o));

  a_r9_reset_idle: assert property (@(posedge clk_i)
    !rst_ni |-> (in_ready_o && !out_valid_o && (y_o == '0)));
endmodule

bind da_fir_filter da_fir_checker #(.B(SAMPLE_W), .OUT_W(OUT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i),
  .in_ready_o(in_ready_o), .out_valid_o(out_valid_o), .y_o(y_o)
);

// File: tb/sim_da_fir_filter.sv
module sim_da_fir_filter;
  localparam int B = 8;
  localparam int K = 4;
  localparam int OUT_W = 18;
  localparam int C [K] = '{3, -7, 12, -128};
  localparam int N_STIM = 14;
  localparam int STIM [N_STIM] = '{1, 0, 0, 0, -128, 127, -1, 55,
                                   -128, -128, -128, -128, 100, -37};
  localparam int N_BURST = 5;
  localparam int BURST [N_BURST] = '{9, -100, 64, -1, 127};

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b1;
  logic             in_valid_i = 1'b0;
  logic             in_ready_o;
  logic [B-1:0]     sample_i = '0;
  logic             out_valid_o;
  logic [OUT_W-1:0] y_o;

  int  total = 0, fails = 0, cycles = 0;
  bit  done = 1'b0;
  int  hist [K];

  always #5 clk_i = ~clk_i;

  da_fir_filter u0 (.*);

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint ysig();
    return longint'($signed(y_o));
  endfunction

  function automatic longint push(input int s);
    longint r = 0;
    for (int k = K - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = s;
    for (int k = 0; k < K; k++) r += longint'(C[k]) * longint'(hist[k]);
    return r;
  endfunction

  // one sample; poke offers a stray sample while busy (R6)
  task automatic run_one(input int s, input bit poke, input string req);
    longint e;
    @(negedge clk_i); in_valid_i = 1'b1; sample_i = B'(s);
    while (!in_ready_o) @(negedge clk_i);
    @(posedge clk_i); e = push(s);
    @(negedge clk_i);
    if (poke) begin
      sample_i = B'(77);
      repeat (B - 3) @(negedge clk_i);
      chk("R3 ready low mid-computation", in_ready_o, 0);
      @(negedge clk_i); in_valid_i = 1'b0;
      @(negedge clk_i);
    end else begin
      in_valid_i = 1'b0;
      repeat (B - 1) @(negedge clk_i);
    end
    chk("R4 no early out_valid", out_valid_o, 0);
    chk("R3 ready in last bit cycle", in_ready_o, 1);
    @(negedge clk_i);
    chk("R4 out_valid on time", out_valid_o, 1);
    chk(req, ysig(), e);
    @(negedge clk_i);
    chk("R4 single-cycle pulse", out_valid_o, 0);
    chk("R5 result held", ysig(), e);
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1'b1;
      fails++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    longint prev, cur;
    for (int k = 0; k < K; k++) hist[k] = 0;
    #2 rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R9 reset ready", in_ready_o, 1);
    chk("R9 reset out_valid", out_valid_o, 0);
    chk("R9 reset y", ysig(), 0);
    rst_ni = 1'b1;

    // R1 R2 R8: table walk; the first four give the impulse response
    for (int i = 0; i < N_STIM; i++) run_one(STIM[i], 1'b0, "R1 R2 R8 result");

    // R6: stray sample offered while busy, later results must not see it
    run_one(20, 1'b1, "R6 result with stray offer");
    run_one(-3, 1'b0, "R6 history unaffected");
    run_one(0, 1'b0, "R6 history unaffected");

    // R7: back-to-back stream
    @(negedge clk_i); in_valid_i = 1'b1; sample_i = B'(BURST[0]);
    chk("R7 idle ready", in_ready_o, 1);
    @(posedge clk_i); prev = push(BURST[0]);
    @(negedge clk_i);
    for (int i = 1; i < N_BURST; i++) begin
      sample_i = B'(BURST[i]);
      chk("R3 R7 ready low after accept", in_ready_o, 0);
      repeat (B - 1) @(posedge clk_i);
      @(negedge clk_i);
      chk("R7 ready every B cycles", in_ready_o, 1);
      @(posedge clk_i); cur = push(BURST[i]);
      @(negedge clk_i);
      chk("R7 out_valid", out_valid_o, 1);
      chk("R7 result", ysig(), prev);
      prev = cur;
    end
    in_valid_i = 1'b0;
    repeat (B) @(negedge clk_i);
    chk("R7 last out_valid", out_valid_o, 1);
    chk("R7 last result", ysig(), prev);

    // R9: reset in the middle of a computation
    @(negedge clk_i); in_valid_i = 1'b1; sample_i = B'(50);
    @(posedge clk_i);
    @(negedge clk_i); in_valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R9 async ready", in_ready_o, 1);
    chk("R9 async out_valid", out_valid_o, 0);
    chk("R9 async y", ysig(), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    for (int k = 0; k < K; k++) hist[k] = 0;
    repeat (B + 2) begin
      @(negedge clk_i);
      chk("R9 no stale result", out_valid_o, 0);
    end
    run_one(5, 1'b0, "R9 taps cleared");

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule